// File: doc/BRIEF.md
# Annunciator Multiplexed Waveform Generator

This block drives a small group of status indicators that share a single common row electrode. For every indicator column it produces a logic-level waveform whose timing against the common row waveform decides whether that segment is dark or lit. A dark segment sees the same waveform on both of its electrodes, so the voltage across it stays at zero. A lit segment sees a train of positive pulses and then an equal train of negative pulses, so it gets an alternating drive with no net DC component.

The block advances one pattern slot on each pulse of a single-cycle enable, `tick`. This enable comes from a 1024 Hz strobe, which is sixteen times the 64 Hz frame rate, so one full pattern lasts one frame. The pattern has `4*PULSES` slots. In the first half the row pulses high on the even slots. In the second half the row stays low and lit columns pulse high on the even slots instead. The on/off mask is captured only at the start of each pattern, so a column never emits half of one waveform and half of the other. The outputs are logic levels; voltage translation happens outside the block.

Column index assignment: bit 0 is left shift, bit 1 is right shift, bit 2 is alpha, bit 3 is low battery, bit 4 is busy and bit 5 is I/O.

Top module: `annun_wavegen`

## Requirements
- R1: While `rst` is high and on the cycle after it, `row_o` and all of `col_o` are 0. The first `tick` after reset moves the block into slot 0 of a new pattern and captures `lit_mask` at that point.
- R2: Slots are numbered 0 to 15 (with PULSES=4). After the tick that enters slot s, `row_o` is 1 exactly when s is even and s < 8.
- R3: A column whose captured mask bit is 0 outputs the same value as `row_o` on every cycle.
- R4: A column whose captured mask bit is 1 is 0 in slots 0 to 7, and is 1 exactly in slots 8, 10, 12 and 14.
- R5: Outputs change only on a clock edge where `tick` is 1. Without a tick, they hold.
- R6: A change of `lit_mask` during slots 1 to 15 has no effect on any output until the tick that enters the next slot 0.
- R7: The mask value present at the tick that enters slot 0 governs all 16 slots of that pattern.
- R8: Each mask bit i controls only column i. Any combination of lit and dark columns may be shown at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Single-cycle slot-advance enable (1024 Hz strobe) |
| lit_mask | input | N_COLS | Per-column on request, 1 = lit |
| row_o | output | 1 | Common row waveform |
| col_o | output | N_COLS | Column waveforms, bit i for indicator i |

## Verification
The bench changes the mask in the middle of a pattern. A design that samples the mask on every tick would switch a column mid-pattern and leave a segment with a DC imbalance. Long gaps between ticks show whether the outputs move without an enable. The bench also covers the wrap from slot 15 to slot 0, a reset in the middle of a run, and a walking single lit column. These catch an off-by-one in the half-pattern boundary, a row left high across the idle half, and a crossed column index.

// File: rtl/annun_pkg.sv
package annun_pkg;
  localparam int ANN_COLS = 6;

  typedef enum int {
    ANN_LSHIFT  = 0,
    ANN_RSHIFT  = 1,
    ANN_ALPHA   = 2,
    ANN_LOWBAT  = 3,
    ANN_BUSY    = 4,
    ANN_IO      = 5
  } annun_idx_e;
endpackage

// File: rtl/annun_phase.sv
module annun_phase #(
  parameter int SLOTS = 16,
  localparam int PHW = $clog2(SLOTS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  output logic [PHW-1:0] phase_q,
  output logic [PHW-1:0] phase_nxt,
  output logic           wrap
);
  always_comb begin
    if (phase_q == PHW'(SLOTS - 1)) phase_nxt = '0;
    else                            phase_nxt = phase_q + 1'b1;
  end

  assign wrap = tick && (phase_nxt == '0);

  always_ff @(posedge clk) begin
    if (rst)       phase_q <= PHW'(SLOTS - 1);
    else if (tick) phase_q <= phase_nxt;
  end
endmodule

// File: rtl/annun_mask_latch.sv
module annun_mask_latch #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [N-1:0] mask_in,
  output logic [N-1:0] mask_q,
  output logic [N-1:0] mask_eff
);
  assign mask_eff = load ? mask_in : mask_q;

  always_ff @(posedge clk) begin
    if (rst)       mask_q <= '0;
    else if (load) mask_q <= mask_in;
  end
endmodule

// File: rtl/annun_slot_drv.sv
module annun_slot_drv #(
  parameter int SLOTS = 16,
  localparam int PHW  = $clog2(SLOTS),
  localparam int HALF = SLOTS / 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [PHW-1:0] phase_nxt,
  input  logic           lit_sel,
  output logic           drv_q
);
  logic pulse_slot;
  logic in_half;
  logic level;

  assign pulse_slot = ~phase_nxt[0];
  assign in_half    = lit_sel ? (phase_nxt >= PHW'(HALF)) : (phase_nxt < PHW'(HALF));
  assign level      = pulse_slot & in_half;

  always_ff @(posedge clk) begin
    if (rst)       drv_q <= 1'b0;
    else if (tick) drv_q <= level;
  end
endmodule

// File: rtl/annun_wavegen.sv
module annun_wavegen #(
  parameter int N_COLS = annun_pkg::ANN_COLS,
  parameter int PULSES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [N_COLS-1:0] lit_mask,
  output logic              row_o,
  output logic [N_COLS-1:0] col_o
);
  localparam int SLOTS = 4 * PULSES;
  localparam int PHW   = $clog2(SLOTS);

  logic [PHW-1:0]    phase_q;
  logic [PHW-1:0]    phase_nxt;
  logic              wrap;
  logic [N_COLS-1:0] mask_q;
  logic [N_COLS-1:0] mask_eff;

  annun_phase #(.SLOTS(SLOTS)) u_phase (
    .clk(clk), .rst(rst), .tick(tick),
    .phase_q(phase_q), .phase_nxt(phase_nxt), .wrap(wrap)
  );

  annun_mask_latch #(.N(N_COLS)) u_mask (
    .clk(clk), .rst(rst), .load(wrap),
    .mask_in(lit_mask), .mask_q(mask_q), .mask_eff(mask_eff)
  );

  annun_slot_drv #(.SLOTS(SLOTS)) u_row (
    .clk(clk), .rst(rst), .tick(tick),
    .phase_nxt(phase_nxt), .lit_sel(1'b0), .drv_q(row_o)
  );

  for (genvar gi = 0; gi < N_COLS; gi++) begin : g_col
    annun_slot_drv #(.SLOTS(SLOTS)) u_col (
      .clk(clk), .rst(rst), .tick(tick),
      .phase_nxt(phase_nxt), .lit_sel(mask_eff[gi]), .drv_q(col_o[gi])
    );
  end
endmodule

// File: rtl/annun_wavegen_chk.sv
module annun_wavegen_chk #(
  parameter int N    = 6,
  parameter int PHW  = 4,
  parameter int HALF = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           tick,
  input logic           row_o,
  input logic [N-1:0]   col_o,
  input logic [PHW-1:0] phase_q,
  input logic [N-1:0]   mask_q
);
  // R1: outputs cleared by reset
  a_r1_reset_low: assert property (@(posedge clk) rst |=> (!row_o && col_o == '0));

  // R2: row only high on an even slot in the pulse half
  a_r2_row_slot: assert property (@(posedge clk) disable iff (rst)
    row_o |-> (!phase_q[0] && phase_q < PHW'(HALF)));

  // R3: dark columns follow the row
  a_r3_dark_follow: assert property (@(posedge clk) disable iff (rst)
    ((col_o ^ {N{row_o}}) & ~mask_q) == '0);

  // R4: lit columns only high on even slots of the idle half
  a_r4_lit_slot: assert property (@(posedge clk) disable iff (rst)
    ((col_o & mask_q) != '0) |-> (!phase_q[0] && phase_q >= PHW'(HALF)));

  // R5: no movement without a tick
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(tick) |-> ($stable(row_o) && $stable(col_o)));

  // R6: captured mask only changes at the start of a pattern
  a_r6_mask_wrap: assert property (@(posedge clk) disable iff (rst)
    !$stable(mask_q) |-> (phase_q == '0));
endmodule

bind annun_wavegen annun_wavegen_chk #(
  .N(N_COLS), .PHW(PHW), .HALF(SLOTS / 2)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .row_o(row_o), .col_o(col_o),
  .phase_q(phase_q), .mask_q(mask_q)
);

// File: tb/annun_wavegen_bench.sv
module annun_wavegen_bench;
  import annun_pkg::*;
  localparam int N = ANN_COLS;
  localparam int SLOTS = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick = 1'b0;
  logic [N-1:0] lit_mask = '0;
  logic         row_o;
  logic [N-1:0] col_o;

  int n_checks = 0;
  int n_fail = 0;
  int slot = SLOTS - 1;
  logic [N-1:0] exp_mask = '0;

  always #4 clk = ~clk;

  annun_wavegen u_annun_wavegen (
    .clk(clk), .rst(rst), .tick(tick), .lit_mask(lit_mask),
    .row_o(row_o), .col_o(col_o)
  );

  task automatic check(input string req);
    logic         erow;
    logic         elit;
    logic [N-1:0] ecol;
    erow = (slot % 2 == 0) && (slot < SLOTS / 2);
    elit = (slot % 2 == 0) && (slot >= SLOTS / 2);
    for (int i = 0; i < N; i++) ecol[i] = exp_mask[i] ? elit : erow;
    n_checks++;
    if (row_o !== erow || col_o !== ecol) begin
      n_fail++;
      $display("FAIL %s slot %0d: row=%b col=%b expected row=%b col=%b",
               req, slot, row_o, col_o, erow, ecol);
    end
  endtask

  // one clock cycle, with or without a tick, then compare
  task automatic step(input bit t, input string req);
    tick = t;
    @(negedge clk);
    tick = 1'b0;
    if (t) begin
      slot = (slot + 1) % SLOTS;
      if (slot == 0) exp_mask = lit_mask;
    end
    check(req);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    slot = SLOTS - 1;
    exp_mask = '0;
    check("R1");
  endtask

  // R2 R3: all columns dark over two patterns
  task automatic t_all_dark();
    lit_mask = '0;
    for (int k = 0; k < 2 * SLOTS; k++) step(1'b1, "R2/R3");
  endtask

  // R4 R7: all columns lit over two patterns
  task automatic t_all_lit();
    while (slot != SLOTS - 1) step(1'b1, "R4");
    lit_mask = '1;
    for (int k = 0; k < 2 * SLOTS; k++) step(1'b1, "R4/R7");
  endtask

  // R5: outputs hold between sparse ticks
  task automatic t_hold();
    lit_mask = 6'b010101;
    for (int k = 0; k < 20; k++) begin
      step(1'b1, "R5");
      for (int g = 0; g < 3; g++) step(1'b0, "R5");
    end
  endtask

  // R6 R7: mask change mid-pattern deferred to next slot 0
  task automatic t_midchange();
    while (slot != 3) step(1'b1, "R6");
    lit_mask = ~exp_mask;
    for (int k = 0; k < SLOTS; k++) step(1'b1, "R6");
    lit_mask = 6'b001100;
    for (int k = 0; k < SLOTS; k++) step(1'b1, "R6/R7");
  endtask

  // R8: walking single lit column
  task automatic t_walk();
    for (int i = 0; i < N; i++) begin
      while (slot != SLOTS - 1) step(1'b1, "R8");
      lit_mask = N'(1) << i;
      for (int k = 0; k < SLOTS; k++) step(1'b1, "R8");
    end
    lit_mask = '0;
    lit_mask[ANN_BUSY] = 1'b1;
    lit_mask[ANN_LSHIFT] = 1'b1;
    for (int k = 0; k < 2 * SLOTS; k++) step(1'b1, "R8");
  endtask

  // R1: reset in the middle of a pattern
  task automatic t_mid_reset();
    lit_mask = '1;
    while (slot != 9) step(1'b1, "R1");
    do_reset();
    step(1'b0, "R1");
    lit_mask = 6'b100001;
    for (int k = 0; k < SLOTS; k++) step(1'b1, "R1");
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    t_all_dark();
    t_all_lit();
    t_hold();
    t_midchange();
    t_walk();
    t_mid_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule